// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block gives on-chip logic access to the 16-bit control-register space inside a serial PHY. The PHY exposes that space through a four-phase request/acknowledge port. The block accepts one command at a time on a valid/ready interface. A command is an address capture, a register write or a register read. The block turns each command into the sequence of strobes the PHY expects and reports the outcome with a single-cycle done pulse.

The block drives a 20-bit control word toward the PHY and reads a 20-bit status word back. Each strobe is held until the acknowledge flag reads high, and then withdrawn until the flag reads low. The acknowledge flag is sampled once every `POLL_GAP` clock cycles. Each wait takes at most `POLL_LIMIT` samples, so a PHY that never answers turns into an error report rather than a hung master. The status word can pass through `SYNC_STAGES` flip-flops before it is used. Setting that parameter to zero removes the synchronizer.

Top module: `phy_cr_master`

## Requirements
- R1: After reset, `phy_ctl` is zero, `cmd_ready` is high and `done` is low.
- R2: Field positions and encodings:
  - Control word: value in bits 15:0, address-capture strobe in bit 16, data-capture strobe in bit 17, write strobe in bit 18, read strobe in bit 19. At most one strobe bit is set at any time.
  - Status word: read data in bits 15:0, acknowledge in bit 18.
  - `cmd_op` encoding: 0 = address, 1 = write, 2 = read, 3 = reserved.
- R3: An address command drives the value with bit 16 set until acknowledge is seen high. It then drives the value alone until acknowledge is seen low, and finishes with `done_err` = 0.
- R4: A write command runs four phases, each advancing on the acknowledge level it waits for:
  - value with bit 16 replaced by bit 17 (data capture), waiting for high;
  - value alone, waiting for low;
  - value with bit 18 (write strobe), waiting for high;
  - an all-zero word, waiting for low.
- R5: A read command drives only bit 19 until acknowledge is seen high. It captures status bits 15:0 at that sample, then drives zero until acknowledge is seen low. The captured value appears on `done_rdata` with the done pulse.
- R6: Acknowledge is sampled in the first cycle of each phase and then every `POLL_GAP` cycles. A matching sample moves the control word to the next phase at the next clock edge. After the last phase matches, `done` rises and `phy_ctl` returns to zero at that same edge.
- R7: A phase whose `POLL_LIMIT`-th sample still does not match aborts the command at the next edge. The abort sets `phy_ctl` to zero and gives a done pulse with `done_err` = 1. A match on the last allowed sample still succeeds.
- R8: After an abort the block is idle, and the next command runs normally.
- R9: A reserved operation is accepted and yields a done pulse with `done_err` = 1 in the following cycle, without any change of `phy_ctl`.
- R10: `done` lasts one cycle. `cmd_ready` is low from the accepting edge until after the done cycle, and a command is taken only when `cmd_valid` and `cmd_ready` are both high.
- R11: `done_rdata` is zero with every done pulse except a successful read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | Operation: 0 address, 1 write, 2 read, 3 reserved |
| cmd_value | input | DATA_W | Address or write data |
| phy_ctl | output | CTL_W | Control word toward the PHY |
| phy_stat | input | STAT_W | Status word from the PHY |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Command aborted or reserved, valid with done |
| done_rdata | output | DATA_W | Read result, valid with done |

## Verification
Address, write and read commands are issued against a responder that answers after a short delay. This separates the phase order of the three operations and shows the captured read data. A responder delay that lands the acknowledge exactly on the final allowed sample, and one that misses it by a single cycle, pins down the poll count and the sampling interval. A responder that never acknowledges, and one whose acknowledge never falls, show that aborts occur in both the rising and the falling wait, with the control word cleared and read data suppressed. A reserved operation and a normal command after each abort show the recovery path.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

   // Control word strobe positions (decoded by the PHY)
   localparam int unsigned CTL_CAP_ADDR = 16;
   localparam int unsigned CTL_CAP_DATA = 17;
   localparam int unsigned CTL_WR_STB   = 18;
   localparam int unsigned CTL_RD_STB   = 19;
   // Status word acknowledge position
   localparam int unsigned STAT_ACK     = 18;

   typedef enum logic [1:0] {
      OP_ADDR  = 2'd0,
      OP_WRITE = 2'd1,
      OP_READ  = 2'd2,
      OP_RSVD  = 2'd3
   } cr_op_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } cr_state_e;

endpackage

// File: rtl/phy_cr_stat_sync.sv
module phy_cr_stat_sync #(
   parameter int unsigned WIDTH  = 20,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [WIDTH-1:0] pipe_q [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int s = 0; s < int'(STAGES); s++) pipe_q[s] <= '0;
            end else begin
               pipe_q[0] <= d_in;
               for (int s = 1; s < int'(STAGES); s++) pipe_q[s] <= pipe_q[s-1];
            end
         end
         assign d_out = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/phy_cr_ack_poller.sv
module phy_cr_ack_poller #(
   parameter int unsigned POLL_LIMIT = 101,
   parameter int unsigned POLL_GAP   = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic want_level,
   input  logic ack,
   output logic hit,
   output logic expired
);

   localparam int unsigned GAP_W = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
   localparam int unsigned CNT_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
   localparam logic [GAP_W-1:0] GAP_RELOAD = GAP_W'(POLL_GAP - 1);
   localparam logic [CNT_W-1:0] LAST_IDX   = CNT_W'(POLL_LIMIT - 1);

   logic [GAP_W-1:0] gap_q;
   logic [CNT_W-1:0] idx_q;
   logic             sample;

   assign sample  = active && (gap_q == '0);
   assign hit     = sample && (ack == want_level);
   assign expired = sample && (ack != want_level) && (idx_q == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q <= '0;
         idx_q <= '0;
      end else if (!active || hit || expired) begin
         gap_q <= '0;
         idx_q <= '0;
      end else if (sample) begin
         gap_q <= GAP_RELOAD;
         idx_q <= idx_q + 1'b1;
      end else begin
         gap_q <= gap_q - 1'b1;
      end
   end

endmodule

// File: rtl/phy_cr_seq.sv
module phy_cr_seq
   import phy_cr_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CTL_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_value,
   input  logic [DATA_W-1:0] stat_data,
   input  logic              hit,
   input  logic              expired,
   output logic              poll_active,
   output logic              want_level,
   output logic [CTL_W-1:0]  phy_ctl,
   output logic              done,
   output logic              done_err,
   output logic [DATA_W-1:0] done_rdata
);

   cr_state_e         state_q;
   cr_op_e            op_q;
   logic [DATA_W-1:0] val_q;
   logic [1:0]        step_q;
   logic [DATA_W-1:0] rdata_q;
   logic [1:0]        last_step;

   // Control word for one phase of one operation
   function automatic logic [CTL_W-1:0] phase_word(cr_op_e op, logic [1:0] step,
                                                    logic [DATA_W-1:0] val);
      logic [CTL_W-1:0] w;
      w = '0;
      unique case (op)
         OP_ADDR: begin
            w[DATA_W-1:0] = val;
            if (step == 2'd0) w[CTL_CAP_ADDR] = 1'b1;
         end
         OP_WRITE: begin
            if (step != 2'd3) w[DATA_W-1:0] = val;
            if (step == 2'd0) w[CTL_CAP_DATA] = 1'b1;
            if (step == 2'd2) w[CTL_WR_STB]   = 1'b1;
         end
         OP_READ: begin
            if (step == 2'd0) w[CTL_RD_STB] = 1'b1;
         end
         default: w = '0;
      endcase
      return w;
   endfunction

   assign last_step   = (op_q == OP_WRITE) ? 2'd3 : 2'd1;
   assign cmd_ready   = (state_q == ST_IDLE) && !done;
   assign poll_active = (state_q == ST_RUN);
   assign want_level  = ~step_q[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         op_q       <= OP_ADDR;
         val_q      <= '0;
         step_q     <= '0;
         rdata_q    <= '0;
         phy_ctl    <= '0;
         done       <= 1'b0;
         done_err   <= 1'b0;
         done_rdata <= '0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (cmd_valid && cmd_ready) begin
                  if (cr_op_e'(cmd_op) == OP_RSVD) begin
                     done       <= 1'b1;
                     done_err   <= 1'b1;
                     done_rdata <= '0;
                  end else begin
                     state_q <= ST_RUN;
                     op_q    <= cr_op_e'(cmd_op);
                     val_q   <= cmd_value;
                     step_q  <= 2'd0;
                     phy_ctl <= phase_word(cr_op_e'(cmd_op), 2'd0, cmd_value);
                  end
               end
            end
            ST_RUN: begin
               if (expired) begin
                  state_q    <= ST_IDLE;
                  phy_ctl    <= '0;
                  done       <= 1'b1;
                  done_err   <= 1'b1;
                  done_rdata <= '0;
               end else if (hit) begin
                  if (op_q == OP_READ && step_q == 2'd0) rdata_q <= stat_data;
                  if (step_q == last_step) begin
                     state_q    <= ST_IDLE;
                     phy_ctl    <= '0;
                     done       <= 1'b1;
                     done_err   <= 1'b0;
                     done_rdata <= (op_q == OP_READ) ? rdata_q : '0;
                  end else begin
                     step_q  <= step_q + 1'b1;
                     phy_ctl <= phase_word(op_q, step_q + 1'b1, val_q);
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
   import phy_cr_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned CTL_W       = 20,
   parameter int unsigned STAT_W      = 20,
   parameter int unsigned POLL_LIMIT  = 101,
   parameter int unsigned POLL_GAP    = 5000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_value,
   output logic [CTL_W-1:0]  phy_ctl,
   input  logic [STAT_W-1:0] phy_stat,
   output logic              done,
   output logic              done_err,
   output logic [DATA_W-1:0] done_rdata
);

   generate
      if (DATA_W != CTL_CAP_ADDR) begin : g_bad_data_w
         $error("DATA_W must equal the address-capture bit position");
      end
      if (CTL_W <= CTL_RD_STB) begin : g_bad_ctl_w
         $error("CTL_W too narrow for the strobe fields");
      end
      if (STAT_W <= STAT_ACK) begin : g_bad_stat_w
         $error("STAT_W too narrow for the acknowledge flag");
      end
      if (POLL_LIMIT < 1 || POLL_GAP < 1) begin : g_bad_poll
         $error("POLL_LIMIT and POLL_GAP must be at least 1");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   logic [STAT_W-1:0] stat_s;
   logic              hit;
   logic              expired;
   logic              poll_active;
   logic              want_level;
   logic              unused_stat;

   assign unused_stat = ^stat_s;

   phy_cr_stat_sync #(
      .WIDTH  (STAT_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (phy_stat),
      .d_out (stat_s)
   );

   phy_cr_ack_poller #(
      .POLL_LIMIT (POLL_LIMIT),
      .POLL_GAP   (POLL_GAP)
   ) u_poll (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (poll_active),
      .want_level (want_level),
      .ack        (stat_s[STAT_ACK]),
      .hit        (hit),
      .expired    (expired)
   );

   phy_cr_seq #(
      .DATA_W (DATA_W),
      .CTL_W  (CTL_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cmd_valid),
      .cmd_ready   (cmd_ready),
      .cmd_op      (cmd_op),
      .cmd_value   (cmd_value),
      .stat_data   (stat_s[DATA_W-1:0]),
      .hit         (hit),
      .expired     (expired),
      .poll_active (poll_active),
      .want_level  (want_level),
      .phy_ctl     (phy_ctl),
      .done        (done),
      .done_err    (done_err),
      .done_rdata  (done_rdata)
   );

endmodule

// File: rtl/phy_cr_master_chk.sv
module phy_cr_master_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CTL_W  = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_ready,
   input logic [CTL_W-1:0]  phy_ctl,
   input logic              ack_s,
   input logic              done,
   input logic              done_err,
   input logic [DATA_W-1:0] done_rdata
);

   // R2
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(phy_ctl[19:16]) <= 1);

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (phy_ctl == '0));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cmd_ready);

   // R11
   err_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_err) |-> (done_rdata == '0));

   // R6
   strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((phy_ctl[19:16] != 4'b0) && !ack_s) |=> ($stable(phy_ctl) || (done && done_err)));

endmodule

bind phy_cr_master phy_cr_master_chk #(
   .DATA_W (DATA_W),
   .CTL_W  (CTL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_ready  (cmd_ready),
   .phy_ctl    (phy_ctl),
   .ack_s      (stat_s[phy_cr_pkg::STAT_ACK]),
   .done       (done),
   .done_err   (done_err),
   .done_rdata (done_rdata)
);

// File: tb/phy_cr_master_bench.sv
`timescale 1ns/1ps
module phy_cr_master_bench;

   localparam int GAP   = 3;
   localparam int LIMIT = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [1:0]  cmd_op = 2'd0;
   logic [15:0] cmd_value = 16'h0;
   logic [19:0] phy_ctl;
   logic [19:0] phy_stat;
   logic        done, done_err;
   logic [15:0] done_rdata;

   always #10 clk = ~clk;

   phy_cr_master #(
      .POLL_LIMIT  (LIMIT),
      .POLL_GAP    (GAP),
      .SYNC_STAGES (0)
   ) u_phy_cr_master (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_ready  (cmd_ready),
      .cmd_op     (cmd_op),
      .cmd_value  (cmd_value),
      .phy_ctl    (phy_ctl),
      .phy_stat   (phy_stat),
      .done       (done),
      .done_err   (done_err),
      .done_rdata (done_rdata)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // PHY responder: mode 0 normal, 1 never acknowledges, 2 acknowledge never falls
   int   resp_mode = 0;
   int   resp_dly  = 1;
   int   resp_cnt  = 0;
   logic ack = 1'b0;
   logic [15:0] rd_word = 16'hA5C3;
   assign phy_stat = {1'b0, ack, 2'b00, rd_word};

   always @(posedge clk) begin
      if (!rst_n) begin
         ack <= 1'b0;
         resp_cnt = 0;
      end else if (resp_mode == 1) begin
         ack <= 1'b0;
      end else if ((|phy_ctl[19:16]) != ack) begin
         if (resp_cnt >= resp_dly) begin
            if (!(resp_mode == 2 && ack)) ack <= |phy_ctl[19:16];
            resp_cnt = 0;
         end else begin
            resp_cnt++;
         end
      end else begin
         resp_cnt = 0;
      end
   end

   // Behavioural reference model
   bit          m_busy = 0;
   int          m_step = 0;
   int          m_el = 0;
   logic [1:0]  m_op = 2'd0;
   logic [15:0] m_val = 16'h0;
   logic [15:0] m_lat = 16'h0;
   logic [19:0] e_ctl = 20'h0;
   logic        e_done = 1'b0;
   logic        e_err = 1'b0;
   logic [15:0] e_rd = 16'h0;

   function automatic logic [19:0] mword(logic [1:0] op, int step, logic [15:0] v);
      case (op)
         2'd0: return (step == 0) ? {4'b0001, v} : {4'b0000, v};
         2'd1: begin
            if (step == 0) return {4'b0010, v};
            if (step == 1) return {4'b0000, v};
            if (step == 2) return {4'b0100, v};
            return 20'h0;
         end
         2'd2: return (step == 0) ? 20'h80000 : 20'h0;
         default: return 20'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; e_ctl = 0; e_done = 0; e_err = 0; e_rd = 0;
      end else begin
         bit rdy;
         rdy = !m_busy && !e_done;
         e_done = 0;
         if (!m_busy) begin
            if (cmd_valid && rdy) begin
               m_op = cmd_op;
               if (cmd_op == 2'd3) begin
                  e_done = 1; e_err = 1; e_rd = 0;
               end else begin
                  m_busy = 1; m_step = 0; m_el = 0; m_val = cmd_value;
                  e_ctl = mword(m_op, 0, m_val);
               end
            end
         end else begin
            bit smp, want;
            int last;
            smp  = (m_el % GAP) == 0;
            want = (m_step % 2) == 0;
            last = (m_op == 2'd1) ? 3 : 1;
            if (smp && phy_stat[18] == want) begin
               if (m_op == 2'd2 && m_step == 0) m_lat = phy_stat[15:0];
               if (m_step == last) begin
                  m_busy = 0; e_ctl = 0; e_done = 1; e_err = 0;
                  e_rd = (m_op == 2'd2) ? m_lat : 16'h0;
               end else begin
                  m_step++; m_el = 0;
                  e_ctl = mword(m_op, m_step, m_val);
               end
            end else if (smp && (m_el / GAP) == LIMIT - 1) begin
               m_busy = 0; e_ctl = 0; e_done = 1; e_err = 1; e_rd = 0;
            end else begin
               m_el++;
            end
         end
      end
   end

   // Cycle-by-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         string ctag;
         ctag = !m_busy ? "R8" : (m_op == 2'd0) ? "R3" : (m_op == 2'd1) ? "R4" : "R5";
         chk({ctag, " phy_ctl"}, 32'(phy_ctl), 32'(e_ctl));
         chk("R10 cmd_ready", 32'(cmd_ready), 32'(!m_busy && !e_done));
         chk("R6 done", 32'(done), 32'(e_done));
         if (e_done) begin
            chk("R7 done_err", 32'(done_err), 32'(e_err));
            chk((m_op == 2'd2 && !e_err) ? "R5 done_rdata" : "R11 done_rdata",
                32'(done_rdata), 32'(e_rd));
         end
      end
   end

   // Command driver
   logic        got_err;
   logic [15:0] got_rd;
   logic [19:0] first_ctl;

   task automatic run_cmd(logic [1:0] op, logic [15:0] v);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_value = v;
      @(negedge clk);
      cmd_valid = 1'b0;
      first_ctl = phy_ctl;
      chk("R10 ready drops after accept", 32'(cmd_ready), 32'h0);
      for (int i = 0; i < 500; i++) begin
         if (done) break;
         @(negedge clk);
      end
      got_err = done_err;
      got_rd  = done_rdata;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 phy_ctl", 32'(phy_ctl), 32'h0);
      chk("R1 cmd_ready", 32'(cmd_ready), 32'h1);
      chk("R1 done", 32'(done), 32'h0);
      rst_n = 1'b1;

      resp_dly = 1;
      run_cmd(2'd0, 16'h7F3F);
      chk("R2 address capture word", 32'(first_ctl), 32'h17F3F);
      chk("R3 address ok", 32'(got_err), 32'h0);

      run_cmd(2'd1, 16'h0001);
      chk("R2 data capture word", 32'(first_ctl), 32'h20001);
      chk("R4 write ok", 32'(got_err), 32'h0);
      chk("R11 write rdata", 32'(got_rd), 32'h0);

      rd_word = 16'h2003;
      run_cmd(2'd2, 16'hFFFF);
      chk("R2 read strobe word", 32'(first_ctl), 32'h80000);
      chk("R5 read data", 32'(got_rd), 32'h2003);

      run_cmd(2'd3, 16'h1234);
      chk("R9 reserved error", 32'(got_err), 32'h1);
      chk("R9 reserved ctl", 32'(phy_ctl), 32'h0);

      // boundary: acknowledge lands on the final allowed sample
      resp_dly = GAP * (LIMIT - 1) - 1;
      run_cmd(2'd0, 16'h00AA);
      chk("R7 last sample succeeds", 32'(got_err), 32'h0);

      // one cycle too late
      resp_dly = GAP * (LIMIT - 1);
      run_cmd(2'd0, 16'h00BB);
      chk("R7 late ack aborts", 32'(got_err), 32'h1);
      repeat (GAP * LIMIT + 2) @(negedge clk);

      resp_dly = 1;
      resp_mode = 1;
      run_cmd(2'd1, 16'h5555);
      chk("R7 no ack aborts", 32'(got_err), 32'h1);
      chk("R7 ctl cleared", 32'(phy_ctl), 32'h0);

      resp_mode = 2;
      run_cmd(2'd2, 16'h0);
      chk("R7 stuck ack aborts read", 32'(got_err), 32'h1);
      chk("R11 aborted read rdata", 32'(got_rd), 32'h0);

      resp_mode = 0;
      repeat (6) @(negedge clk);
      run_cmd(2'd0, 16'h0C0D);
      chk("R8 recovery after abort", 32'(got_err), 32'h0);

      rd_word = 16'h0002;
      run_cmd(2'd2, 16'h0);
      chk("R8 read after abort", 32'(got_rd), 32'h0002);

      repeat (4) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

endmodule